// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block sits on the host side of a management link to a switch. The switch exposes a wide paged register space through a small window of 16-bit management registers. A requester presents one access at a time: page, register offset, a width code, a direction and up to 64 bits of write data. The block turns that access into a series of single 16-bit management register reads and writes on a request/acknowledge port. Bit-level serialisation happens further downstream.

For each access the block first selects the page, unless the page already selected is the one wanted. Write data goes into the data window next. Then the command is issued and its busy bits are polled, with a fixed pause between polls and a fixed limit on the number of polls. A read then collects its data words. The block ends the access with a single done pulse that carries an error flag and the zero-extended read data. The downstream port can report an error on any access, and that error ends the request at once.

Top module: `pras_top`

## Requirements
- R1: During and straight after a synchronous active-low reset, `req_ready` is 1 and `done` and `mg_req` are 0. The remembered page is the invalid value 0xFF, so the first request always selects its page. Requests never use page 0xFF.
- R2: If the requested page differs from the remembered one, the first access writes `{page, 8'h01}` to register 0x10. The page is remembered only once that write is acknowledged without error. If the requested page matches the remembered one, no access to register 0x10 is made.
- R3: A write request writes its data words to registers 0x18, 0x19, … with the least significant word first, all before the command. Width codes: 0 is 8 bits and 1 is 16 bits (one word each), 2 is 32 bits (two words), 3 is 48 bits (three words), and 4 to 7 are 64 bits (four words).
- R4: The command is a write of `{offset, 6'b0, op}` to register 0x11, with op 2'b01 for a write request and 2'b10 for a read request.
- R5: After the command, register 0x11 is read until bits 1:0 come back as 00, with at most POLL_LIMIT (5) reads. Other bits of the poll value are ignored. Between the acknowledge of a busy poll and the next poll request, `mg_req` stays low for exactly POLL_GAP cycles.
- R6: If the last permitted poll still shows busy, the request ends with `err` = 1 and `rdata` = 0, and makes no data read.
- R7: A successful read collects registers 0x18 upward, one per data word, into `rdata`, with word i at bits 16i+15:16i and the upper bits zero. A width-0 read keeps only bits 7:0 of word 0.
- R8: An acknowledge with `mg_err` = 1 ends the request. No further access is made, `done` and `err` are 1 on the next cycle, and `rdata` is 0.
- R9: `mg_req` and the register, direction and data fields stay constant until `mg_ack`. Only one access is outstanding at a time.
- R10: A request is accepted only while `req_ready` is 1, and `req_valid` has no effect otherwise. `done` is a one-cycle pulse in the cycle after the final acknowledge. `err` and `rdata` are 0 outside that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Register offset within the page |
| req_width | input | 3 | Width code (R3) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write data |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request failed, valid with done |
| rdata | output | 64 | Read data, valid with done |
| mg_req | output | 1 | Management access request |
| mg_write | output | 1 | Management access direction |
| mg_reg | output | 5 | Management register number |
| mg_wdata | output | 16 | Management write value |
| mg_ack | input | 1 | Management access complete |
| mg_rdata | input | 16 | Management read value, valid with mg_ack |
| mg_err | input | 1 | Management access failed, valid with mg_ack |

## Verification
A new management request is due one cycle after the acceptance edge or after the previous acknowledge. After a busy poll it is due POLL_GAP cycles later, and `done` is due exactly one cycle after the final acknowledge. The bench builds the expected access list for each request from the requirements. It plays the downstream side with its own latency, busy count and error injection, and compares every access at the falling edge where it acknowledges it. On every falling edge it also checks that `done` appears only in the cycle after the final acknowledge, that held requests keep their fields, and that the idle gap between polls matches.

// File: rtl/pras_pkg.sv
// Shared constants and types for the paged register access sequencer.
package pras_pkg;
    localparam int          MG_REG_W  = 5;
    localparam int          MG_DATA_W = 16;
    localparam int          PAGE_W    = 8;
    localparam int          WORDS_MAX = 4;
    localparam int          DATA_W    = MG_DATA_W * WORDS_MAX;
    localparam int          IDX_W     = $clog2(WORDS_MAX);

    localparam logic [MG_REG_W-1:0] REG_PAGE  = 5'h10;
    localparam logic [MG_REG_W-1:0] REG_CMD   = 5'h11;
    localparam logic [MG_REG_W-1:0] REG_DATA0 = 5'h18;
    localparam logic [1:0]          OP_WR     = 2'b01;
    localparam logic [1:0]          OP_RD     = 2'b10;
    localparam logic [PAGE_W-1:0]   PAGE_NONE = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_PAGE, S_WDATA, S_CMD, S_POLL, S_WAIT, S_RDATA, S_FIN
    } seq_state_t;

    // Number of 16-bit words that a width code spans.
    function automatic logic [IDX_W:0] word_count(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return 3'd1;
            3'd2:       return 3'd2;
            3'd3:       return 3'd3;
            default:    return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pras_page_cache.sv
// Remembers which page the remote window currently points at.
// Assumes: PAGE_NONE is never requested; upd is only raised on a clean page write.
module pras_page_cache
    import pras_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic [PAGE_W-1:0] cmp_page,
    output logic              hit
);
    logic [PAGE_W-1:0] cur_page;

    // Hold the last page written successfully; invalid after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur_page <= PAGE_NONE;
        else if (upd) cur_page <= upd_page;
    end

    assign hit = (cmp_page == cur_page);
endmodule

// File: rtl/pras_poll_pacer.sv
// Counts completion polls and times the pause between them.
// Assumes: POLL_LIMIT >= 1 and POLL_GAP >= 1; clear comes before the first poll.
module pras_poll_pacer #(
    parameter int POLL_LIMIT = 5,
    parameter int POLL_GAP   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic poll_done,
    input  logic gap_load,
    input  logic gap_run,
    output logic last_poll,
    output logic gap_over
);
    localparam int AW = $clog2(POLL_LIMIT + 1);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    logic [AW-1:0] polls;
    logic [GW-1:0] gap_cnt;

    // Number of polls already acknowledged for this command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) polls <= '0;
        else if (poll_done)  polls <= polls + 1'b1;
    end

    // Down-counter for the idle cycles between polls.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_cnt <= '0;
        else if (gap_load)              gap_cnt <= GW'(POLL_GAP - 1);
        else if (gap_run && !gap_over)  gap_cnt <= gap_cnt - 1'b1;
    end

    assign last_poll = (polls == AW'(POLL_LIMIT - 1));
    assign gap_over  = (gap_cnt == '0);
endmodule

// File: rtl/pras_rd_assembler.sv
// Gathers read data words into one wide result, one lane per word.
// Assumes: clear at request start; narrow masks to the low byte of word 0.
module pras_rd_assembler
    import pras_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [IDX_W-1:0]     idx,
    input  logic [MG_DATA_W-1:0] word,
    input  logic                 narrow,
    output logic [DATA_W-1:0]    data
);
    logic [DATA_W-1:0] flat;

    for (genvar g = 0; g < WORDS_MAX; g++) begin : g_lane
        logic [MG_DATA_W-1:0] lane;
        // Capture the word addressed to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                  lane <= '0;
            else if (load && idx == IDX_W'(g))    lane <= word;
        end
        assign flat[g*MG_DATA_W +: MG_DATA_W] = lane;
    end

    assign data = narrow ? {{(DATA_W-8){1'b0}}, flat[7:0]} : flat;
endmodule

// File: rtl/pras_top.sv
// Paged register access sequencer: turns one wide paged access into
// page select, data, command, poll and read-back management accesses.
// Assumes: one management access outstanding; mg_ack is a one-cycle pulse.
module pras_top
    import pras_pkg::*;
#(
    parameter int POLL_LIMIT = 5,
    parameter int POLL_GAP   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_page,
    input  logic [7:0]  req_offset,
    input  logic [2:0]  req_width,
    input  logic        req_write,
    input  logic [63:0] req_wdata,
    output logic        done,
    output logic        err,
    output logic [63:0] rdata,
    output logic        mg_req,
    output logic        mg_write,
    output logic [4:0]  mg_reg,
    output logic [15:0] mg_wdata,
    input  logic        mg_ack,
    input  logic [15:0] mg_rdata,
    input  logic        mg_err
);
    seq_state_t          state;
    logic [PAGE_W-1:0]   r_page, r_off;
    logic [IDX_W:0]      r_nw;
    logic                r_write, r_narrow, err_q;
    logic [DATA_W-1:0]   r_wdata;
    logic [IDX_W-1:0]    widx;
    logic                accept, hit, ack_ok, ack_bad, last_word;
    logic                last_poll, gap_over, poll_busy;
    logic [DATA_W-1:0]   asm_data;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign ack_ok    = mg_req && mg_ack && !mg_err;
    assign ack_bad   = mg_req && mg_ack && mg_err;
    assign last_word = ({1'b0, widx} == r_nw - 1'b1);
    assign poll_busy = (mg_rdata[1:0] != 2'b00);

    pras_page_cache u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (state == S_PAGE && ack_ok),
        .upd_page (r_page),
        .cmp_page (req_page),
        .hit      (hit)
    );

    pras_poll_pacer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == S_CMD && ack_ok),
        .poll_done (state == S_POLL && ack_ok),
        .gap_load  (state == S_POLL && ack_ok && poll_busy && !last_poll),
        .gap_run   (state == S_WAIT),
        .last_poll (last_poll),
        .gap_over  (gap_over)
    );

    pras_rd_assembler u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .load   (state == S_RDATA && ack_ok),
        .idx    (widx),
        .word   (mg_rdata),
        .narrow (r_narrow),
        .data   (asm_data)
    );

    // Latch the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_page   <= '0;
            r_off    <= '0;
            r_nw     <= '0;
            r_write  <= 1'b0;
            r_narrow <= 1'b0;
            r_wdata  <= '0;
        end else if (accept) begin
            r_page   <= req_page;
            r_off    <= req_offset;
            r_nw     <= word_count(req_width);
            r_write  <= req_write;
            r_narrow <= (req_width == 3'd0);
            r_wdata  <= req_wdata;
        end
    end

    // Sequence controller: walks page, data, command, poll and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            widx  <= '0;
            err_q <= 1'b0;
        end else if (ack_bad) begin
            err_q <= 1'b1;
            state <= S_FIN;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    widx  <= '0;
                    err_q <= 1'b0;
                    state <= !hit ? S_PAGE : (req_write ? S_WDATA : S_CMD);
                end
                S_PAGE: if (ack_ok) state <= r_write ? S_WDATA : S_CMD;
                S_WDATA: if (ack_ok) begin
                    widx  <= last_word ? '0 : widx + 1'b1;
                    state <= last_word ? S_CMD : S_WDATA;
                end
                S_CMD: if (ack_ok) state <= S_POLL;
                S_POLL: if (ack_ok) begin
                    if (!poll_busy) begin
                        widx  <= '0;
                        state <= r_write ? S_FIN : S_RDATA;
                    end else if (last_poll) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: if (gap_over) state <= S_POLL;
                S_RDATA: if (ack_ok) begin
                    widx  <= widx + 1'b1;
                    state <= last_word ? S_FIN : S_RDATA;
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Present the management access for the current phase.
    always_comb begin
        mg_req   = 1'b0;
        mg_write = 1'b0;
        mg_reg   = REG_CMD;
        mg_wdata = '0;
        case (state)
            S_PAGE: begin
                mg_req = 1'b1; mg_write = 1'b1; mg_reg = REG_PAGE;
                mg_wdata = {r_page, 8'h01};
            end
            S_WDATA: begin
                mg_req = 1'b1; mg_write = 1'b1;
                mg_reg = REG_DATA0 + MG_REG_W'(widx);
                mg_wdata = r_wdata[widx*MG_DATA_W +: MG_DATA_W];
            end
            S_CMD: begin
                mg_req = 1'b1; mg_write = 1'b1; mg_reg = REG_CMD;
                mg_wdata = {r_off, 6'b0, r_write ? OP_WR : OP_RD};
            end
            S_POLL:  mg_req = 1'b1;
            S_RDATA: begin
                mg_req = 1'b1;
                mg_reg = REG_DATA0 + MG_REG_W'(widx);
            end
            default: ;
        endcase
    end

    assign done  = (state == S_FIN);
    assign err   = done && err_q;
    assign rdata = (done && !err_q) ? asm_data : '0;
endmodule

// File: rtl/pras_checker.sv
// Protocol checker for pras_top, attached through bind.
module pras_checker #(
    parameter int POLL_LIMIT = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_width,
    input logic        req_write,
    input logic        done,
    input logic        err,
    input logic [63:0] rdata,
    input logic        mg_req,
    input logic        mg_write,
    input logic [4:0]  mg_reg,
    input logic [15:0] mg_wdata,
    input logic        mg_ack,
    input logic        mg_err
);
    int   poll_seen;
    logic narrow_q;

    // Count poll reads since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_seen <= 0;
            narrow_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            poll_seen <= 0;
            narrow_q  <= (req_width == 3'd0) && !req_write;
        end else if (mg_req && mg_ack && !mg_write && mg_reg == 5'h11) begin
            poll_seen <= poll_seen + 1;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mg_req && !mg_ack |=> mg_req && $stable(mg_reg) && $stable(mg_write) && $stable(mg_wdata));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mg_req);
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rdata == 64'd0);
    p_page_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mg_req && mg_reg == 5'h10 |-> mg_write && mg_wdata[7:0] == 8'h01);
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mg_req && !mg_write && mg_reg == 5'h11 |-> poll_seen < POLL_LIMIT);
    p_narrow_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && narrow_q |-> rdata[63:8] == 56'd0);
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mg_req && mg_ack && mg_err |=> done && err && !mg_req);
endmodule

bind pras_top pras_checker #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_width (req_width),
    .req_write (req_write),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .mg_req    (mg_req),
    .mg_write  (mg_write),
    .mg_reg    (mg_reg),
    .mg_wdata  (mg_wdata),
    .mg_ack    (mg_ack),
    .mg_err    (mg_err)
);

// File: tb/pras_top_tb.sv
module pras_top_tb;
    localparam int GAP   = 3;
    localparam int LIMIT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_page = '0, req_offset = '0;
    logic [2:0]  req_width = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        done, err;
    logic [63:0] rdata;
    logic        mg_req, mg_write;
    logic [4:0]  mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_ack = 1'b0;
    logic [15:0] mg_rdata = '0;
    logic        mg_err = 1'b0;

    always #4 clk = ~clk;

    pras_top #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offset(req_offset), .req_width(req_width),
        .req_write(req_write), .req_wdata(req_wdata), .done(done), .err(err),
        .rdata(rdata), .mg_req(mg_req), .mg_write(mg_write), .mg_reg(mg_reg),
        .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata), .mg_err(mg_err)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural model state
    logic [21:0] expq[$];
    int          model_page = 255;
    int          busy_left = 0, polls_seen = 0, err_at = -1, acc_idx = 0;
    int          lat = 0, lat_cnt = 0, gap_cnt = 0;
    bit          cur_wr = 0, done_due = 0, done_seen = 0, exp_err = 0;
    bit          gap_on = 0, hold_v = 0;
    logic [63:0] exp_rdata = '0;
    string       exp_tag = "R10";
    logic [15:0] rd_words[4];
    logic [4:0]  h_reg;
    logic        h_wr;
    logic [15:0] h_wd;

    function automatic string tag_of(input logic wr, input logic [4:0] r);
        if (r == 5'h10) return "R2";
        if (r == 5'h11) return wr ? "R4" : "R5";
        return wr ? "R3" : "R7";
    endfunction

    function automatic int words_of(input int w);
        if (w <= 1) return 1;
        if (w == 2) return 2;
        if (w == 3) return 3;
        return 4;
    endfunction

    // Downstream responder and per-cycle comparison, away from the active edge.
    always @(negedge clk) begin : resp
        logic [21:0] e;
        bit ok;
        if (!rst_n) begin
            mg_ack = 1'b0; mg_err = 1'b0; hold_v = 0;
        end else begin
            if (done_due) begin
                chk(done === 1'b1, exp_tag, "done pulse", done, 1);
                chk(err === exp_err, exp_tag, "err flag", err, exp_err);
                chk(rdata === exp_rdata, exp_tag, "read data", rdata, exp_rdata);
                done_due = 0; done_seen = 1;
            end else if (done === 1'b1) begin
                chk(0, "R10", "stray done", done, 0);
            end
            mg_ack = 1'b0; mg_err = 1'b0;
            if (gap_on) begin
                if (!mg_req) gap_cnt++;
                else begin
                    chk(gap_cnt == GAP, "R5", "poll gap", gap_cnt, GAP);
                    gap_on = 0;
                end
            end
            if (hold_v) begin
                chk(mg_req && mg_reg == h_reg && mg_write == h_wr && mg_wdata == h_wd,
                    "R9", "held request", {mg_req, mg_write, mg_reg, mg_wdata},
                    {1'b1, h_wr, h_reg, h_wd});
            end
            hold_v = 0;
            if (mg_req && !gap_on) begin
                if (lat_cnt >= lat) begin
                    lat_cnt = 0;
                    if (expq.size() == 0) begin
                        chk(0, "R9", "unexpected access", {mg_write, mg_reg}, 0);
                    end else begin
                        e = expq.pop_front();
                        ok = (e[21] == mg_write) && (e[20:16] == mg_reg) &&
                             (!mg_write || e[15:0] == mg_wdata);
                        chk(ok, tag_of(e[21], e[20:16]), "access",
                            {mg_write, mg_reg, mg_wdata}, e);
                    end
                    mg_rdata = 16'h0000;
                    if (!mg_write && mg_reg == 5'h11) begin
                        polls_seen++;
                        if (busy_left > 0) begin
                            mg_rdata = cur_wr ? 16'h5A01 : 16'h5A02;
                            busy_left--;
                            if (polls_seen < LIMIT) begin gap_on = 1; gap_cnt = 0; end
                        end else mg_rdata = 16'h5A00;
                    end else if (!mg_write && mg_reg >= 5'h18 && mg_reg <= 5'h1B) begin
                        mg_rdata = rd_words[int'(mg_reg) - 24];
                    end
                    if (acc_idx == err_at) begin
                        mg_err = 1'b1; expq.delete(); gap_on = 0;
                    end else if (mg_write && mg_reg == 5'h10) begin
                        model_page = int'(mg_wdata[15:8]);
                    end
                    acc_idx++;
                    mg_ack = 1'b1;
                    if (expq.size() == 0) done_due = 1;
                end else begin
                    lat_cnt++;
                    hold_v = 1; h_reg = mg_reg; h_wr = mg_write; h_wd = mg_wdata;
                end
            end
        end
    end

    task automatic run(input int page, input int off, input int width, input bit wr,
                       input logic [63:0] wd, input int busy, input int erri,
                       input int latency, input bit spurious);
        int nw, polls;
        nw = words_of(width);
        expq.delete();
        if (page != model_page) expq.push_back({1'b1, 5'h10, 8'(page), 8'h01});
        if (wr) for (int i = 0; i < nw; i++) expq.push_back({1'b1, 5'(24 + i), wd[i*16 +: 16]});
        expq.push_back({1'b1, 5'h11, 8'(off), 6'b0, wr ? 2'b01 : 2'b10});
        polls = (busy >= LIMIT) ? LIMIT : busy + 1;
        for (int i = 0; i < polls; i++) expq.push_back({1'b0, 5'h11, 16'h0});
        if (!wr && busy < LIMIT)
            for (int i = 0; i < nw; i++) expq.push_back({1'b0, 5'(24 + i), 16'h0});
        exp_err = (busy >= LIMIT) || (erri >= 0);
        exp_rdata = '0;
        if (!exp_err && !wr) begin
            for (int i = 0; i < nw; i++) exp_rdata[i*16 +: 16] = rd_words[i];
            if (width == 0) exp_rdata = exp_rdata & 64'hFF;
        end
        exp_tag = (erri >= 0) ? "R8" : (busy >= LIMIT) ? "R6" : (!wr ? "R7" : "R10");
        busy_left = busy; polls_seen = 0; cur_wr = wr; err_at = erri;
        acc_idx = 0; lat = latency; lat_cnt = 0; done_seen = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_page = 8'(page); req_offset = 8'(off);
        req_width = 3'(width); req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (spurious) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
            req_valid = 1'b1; req_page = 8'h33; req_write = ~wr; req_offset = 8'h77;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        chk(expq.size() == 0, "R9", "accesses left over", expq.size(), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rd_words[0] = 16'hBEEF; rd_words[1] = 16'h1234;
        rd_words[2] = 16'hCAFE; rd_words[3] = 16'h8001;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(done === 1'b0, "R1", "done in reset", done, 0);
        chk(mg_req === 1'b0, "R1", "mg_req in reset", mg_req, 0);
        rst_n = 1'b1;
        // R1 R2 R3 R4 R5: first access selects page, one busy poll
        run(3, 8'h20, 1, 1, 64'h0000_0000_0000_A55A, 1, -1, 0, 0);
        // R2: page hit skips page write; R7 32-bit read
        run(3, 8'h04, 2, 0, 64'h0, 0, -1, 1, 0);
        // R3: 64-bit write, new page, slow acks
        run(5, 8'h10, 4, 1, 64'h1111_2222_3333_4444, 2, -1, 2, 0);
        // R3: 48-bit write on cached page
        run(5, 8'h11, 3, 1, 64'h0000_9999_8888_7777, 0, -1, 0, 0);
        // R7: 64-bit read with busy polls
        run(5, 8'h30, 4, 0, 64'h0, 2, -1, 2, 0);
        // R7: 48-bit read
        run(6, 8'h31, 3, 0, 64'h0, 0, -1, 0, 0);
        // R7: 8-bit read keeps low byte only
        run(6, 8'h32, 0, 0, 64'h0, 0, -1, 0, 0);
        // R6: five busy polls time out
        run(6, 8'h40, 1, 0, 64'h0, 5, -1, 0, 0);
        // R5: clear on the fifth poll is success
        run(6, 8'h41, 2, 1, 64'h0000_0000_DEAD_BEEF, 4, -1, 1, 0);
        // R8: page write fails, page must not be remembered
        run(7, 8'h50, 1, 1, 64'h0000_0000_0000_0101, 0, 0, 0, 0);
        run(7, 8'h51, 1, 0, 64'h0, 0, -1, 0, 0);
        // R8: error on second data word of a 64-bit write
        run(7, 8'h52, 6, 1, 64'hAAAA_BBBB_CCCC_DDDD, 0, 1, 1, 0);
        // R10: request while busy is ignored
        run(7, 8'h53, 2, 0, 64'h0, 1, -1, 1, 1);
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule